// File: doc/BRIEF.md
# Self-Repairing Error-Correcting Dual-Port RAM

This block is a 512-word memory with one write port and one read port, each with its own address. Every stored word is 72 bits wide. It carries 64 data bits, 7 Hamming check bits and one bit of even overall parity. The write side builds the check bits and the parity itself. The read side recomputes them, corrects any single flipped bit on its output, and flags words with two flipped bits.

Correcting only the output value would leave the bad word sitting in the array. For that reason a one-entry repair slot captures every corrected word together with its address. It then writes the word back, with freshly generated check bits, in the first cycle the write port is free. A user write always wins the write port. If a user write hits the address that is waiting for repair, the pending repair is discarded. Two saturating counters tally corrected and uncorrectable reads.

A test-only XOR mask on the write port lets a bench flip chosen bits of the encoded word as it is stored.

Top module: `ecc_scrub_ram`

## Requirements
- R1: Stored word bit p (p = 1..71) holds code position p. Power-of-two positions hold check bits, and the other positions hold data bits 0..63 in ascending order. Bit 0 makes the parity of all 72 bits even. `wr_flip` is XORed into this word as it is stored, and a word stored with an all-zero mask reads back with its data intact and both flags low.
- R2: A read sampled on a rising edge with `rd_en` high produces `rd_valid`, `rd_data`, `rd_sec` and `rd_ded` after the next rising edge, two edges in total. `rd_valid` is low in the cycle in between.
- R3: A stored word with exactly one flipped bit, in any of the 72 positions, reads back with the original data, `rd_sec`=1 and `rd_ded`=0.
- R4: A stored word with exactly two flipped bits reads back with `rd_ded`=1 and `rd_sec`=0.
- R5: `rd_sec` and `rd_ded` are never high together, and both are low whenever `rd_valid` is low.
- R6: After a corrected read, the corrected data is re-encoded and written to the same address once the write port is idle. A later read of that address returns the data with both flags low.
- R7: A user write has priority over the repair slot. While `wr_en` stays high, no repair is written, so a re-read of the failing address still reports a corrected error.
- R8: A pending repair is discarded if a user write targets its address before the repair issues. The user's word, including any flipped bits it was stored with, is what later reads return.
- R9: A read flagged as uncorrectable causes no repair. The word keeps reporting `rd_ded` on later reads.
- R10: `sec_count` rises by one in the same edge that raises `rd_sec`, and it saturates at its all-ones value.
- R11: `ded_count` rises by one in the same edge that raises `rd_ded`, and it saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | User write strobe |
| wr_addr | input | ADDR_W | User write address |
| wr_data | input | 64 | User write data |
| wr_flip | input | 72 | XOR mask applied to the encoded word on user writes |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Corrected read data |
| rd_sec | output | 1 | Single error corrected on this read |
| rd_ded | output | 1 | Uncorrectable double error on this read |
| sec_count | output | CNT_W | Saturating count of corrected reads |
| ded_count | output | CNT_W | Saturating count of uncorrectable reads |

## Verification
The assertions watch, on every cycle, the properties that hold in every state:

- the two-edge read latency;
- the exclusivity and quietness of the flags;
- the rule that no repair writes while a user write is on the port;
- the discard of a repair on an address collision;
- the step-by-one and saturation behaviour of both counters.

Only the bench's scenarios can show the rest:

- that the data is actually corrected for single flips in every bit class, including the parity bit, check bits and the top data bit;
- that a repaired word reads back clean;
- that a repair lost to a colliding write leaves the user's word in place;
- that double errors persist.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 7;
    localparam int CW_W   = DATA_W + CHK_W + 1;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef struct packed {
        logic  sec;
        logic  ded;
        data_t data;
    } dec_res_t;

    // position p (1..CW_W-1) is a check position when it is a power of two
    function automatic logic is_chk_pos(input int p);
        return ((p & (p - 1)) == 0);
    endfunction

    // XOR of the indices of all set positions
    function automatic syn_t syn_of(input cw_t cw);
        syn_t s = '0;
        for (int p = 1; p < CW_W; p++)
            if (cw[p]) s ^= syn_t'(p);
        return s;
    endfunction

    function automatic cw_t encode(input data_t d);
        cw_t  cw = '0;
        syn_t s;
        int   j = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                cw[p] = d[j];
                j++;
            end
        end
        s = syn_of(cw);
        for (int k = 0; k < CHK_W; k++)
            cw[1 << k] = s[k];
        cw[0] = ^cw;
        return cw;
    endfunction

    function automatic data_t extract(input cw_t cw);
        data_t d = '0;
        int    j = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_chk_pos(p)) begin
                d[j] = cw[p];
                j++;
            end
        end
        return d;
    endfunction

    function automatic dec_res_t decode(input cw_t cw);
        dec_res_t r;
        cw_t      fixed = cw;
        logic     par   = ^cw;
        syn_t     s     = syn_of(cw);
        r.sec = 1'b0;
        r.ded = 1'b0;
        if (par) begin
            if (int'(s) < CW_W) begin
                fixed[s] = ~fixed[s];
                r.sec    = 1'b1;
            end else begin
                r.ded = 1'b1;
            end
        end else if (s != '0) begin
            r.ded = 1'b1;
        end
        r.data = extract(fixed);
        return r;
    endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_scrub_pkg::*;
(
    input  data_t d,
    input  cw_t   flip,
    output cw_t   cw
);
    assign cw = encode(d) ^ flip;
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_scrub_pkg::*;
(
    input  cw_t      cw,
    output dec_res_t res
);
    assign res = decode(cw);
endmodule

// File: rtl/ecc_wb_slot.sv
module ecc_wb_slot
    import ecc_scrub_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cap_addr,
    input  data_t             cap_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              pend,
    output logic              issue,
    output logic [ADDR_W-1:0] slot_addr,
    output data_t             slot_data
);
    logic collide;

    assign issue   = pend && !wr_en;
    assign collide = pend && wr_en && (wr_addr == slot_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            slot_addr <= '0;
            slot_data <= '0;
        end else if (collide) begin
            pend <= 1'b0;
        end else if (!pend || issue) begin
            pend <= cap_en;
            if (cap_en) begin
                slot_addr <= cap_addr;
                slot_data <= cap_data;
            end
        end
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (inc && cnt != MAXV)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ecc_scrub_ram.sv
module ecc_scrub_ram
    import ecc_scrub_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [71:0]       wr_flip,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              rd_sec,
    output logic              rd_ded,
    output logic [CNT_W-1:0]  sec_count,
    output logic [CNT_W-1:0]  ded_count
);
    localparam int DEPTH = 1 << ADDR_W;

    cw_t               mem [DEPTH];
    cw_t               user_cw, wb_cw, s1_cw;
    logic              s1_valid, s1_stale;
    logic [ADDR_W-1:0] s1_addr;
    dec_res_t          dec_res;
    logic              wb_cap, wb_pend, wb_issue;
    logic [ADDR_W-1:0] wb_addr;
    data_t             wb_data;
    logic              sec_hit, ded_hit;

    ecc_enc u_enc_user (.d(wr_data), .flip(wr_flip), .cw(user_cw));
    ecc_enc u_enc_wb   (.d(wb_data), .flip('0),      .cw(wb_cw));

    // array: user write first, repair only on an idle write port
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= user_cw;
        else if (wb_issue)
            mem[wb_addr] <= wb_cw;
        if (rd_en)
            s1_cw <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_stale <= 1'b0;
            s1_addr  <= '0;
        end else begin
            s1_valid <= rd_en;
            s1_addr  <= rd_addr;
            s1_stale <= wr_en && (wr_addr == rd_addr);
        end
    end

    ecc_dec u_dec (.cw(s1_cw), .res(dec_res));

    assign sec_hit = s1_valid && dec_res.sec;
    assign ded_hit = s1_valid && dec_res.ded;
    // never capture a word that a user write has already superseded
    assign wb_cap  = sec_hit && !s1_stale && !(wr_en && (wr_addr == s1_addr));

    ecc_wb_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (wb_cap),
        .cap_addr  (s1_addr),
        .cap_data  (dec_res.data),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .pend      (wb_pend),
        .issue     (wb_issue),
        .slot_addr (wb_addr),
        .slot_data (wb_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_sec   <= 1'b0;
            rd_ded   <= 1'b0;
        end else begin
            rd_valid <= s1_valid;
            rd_sec   <= sec_hit;
            rd_ded   <= ded_hit;
            if (s1_valid)
                rd_data <= dec_res.data;
        end
    end

    sat_counter #(.W(CNT_W)) u_sec_cnt (.clk(clk), .rst(rst), .inc(sec_hit), .cnt(sec_count));
    sat_counter #(.W(CNT_W)) u_ded_cnt (.clk(clk), .rst(rst), .inc(ded_hit), .cnt(ded_count));

endmodule

// File: rtl/ecc_scrub_ram_chk.sv
module ecc_scrub_ram_chk #(
    parameter int ADDR_W = 9,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              rd_en,
    input logic              rd_valid,
    input logic              rd_sec,
    input logic              rd_ded,
    input logic [CNT_W-1:0]  sec_count,
    input logic [CNT_W-1:0]  ded_count,
    input logic              wb_pend,
    input logic              wb_issue,
    input logic [ADDR_W-1:0] wb_addr
);
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst) rd_en |=> ##1 rd_valid); // R2
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(rd_sec && rd_ded)); // R5
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst) !rd_valid |-> (!rd_sec && !rd_ded)); // R5
    AST_USER_FIRST: assert property (@(posedge clk) disable iff (rst) wr_en |-> !wb_issue); // R7
    AST_REPAIR_DROP: assert property (@(posedge clk) disable iff (rst) (wb_pend && wr_en && wr_addr == wb_addr) |=> !wb_pend); // R8
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst) (sec_count != $past(sec_count)) |-> (rd_sec && sec_count == CNT_W'($past(sec_count) + 1'b1))); // R10
    AST_SEC_SAT: assert property (@(posedge clk) disable iff (rst) (&sec_count) |=> (&sec_count)); // R10
    AST_DED_STEP: assert property (@(posedge clk) disable iff (rst) (ded_count != $past(ded_count)) |-> (rd_ded && ded_count == CNT_W'($past(ded_count) + 1'b1))); // R11
    AST_DED_SAT: assert property (@(posedge clk) disable iff (rst) (&ded_count) |=> (&ded_count)); // R11
endmodule

bind ecc_scrub_ram ecc_scrub_ram_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/ecc_scrub_ram_test.sv
module ecc_scrub_ram_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 9;
    localparam int CNT_W  = 4;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [63:0]       wr_data = '0;
    logic [71:0]       wr_flip = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_valid, rd_sec, rd_ded;
    logic [63:0]       rd_data;
    logic [CNT_W-1:0]  sec_count, ded_count;

    int total = 0;
    int bad   = 0;

    logic [63:0] m_data [512];
    logic [71:0] m_flip [512];
    logic        m_used [512];
    logic [CNT_W-1:0] m_sec = '0;
    logic [CNT_W-1:0] m_ded = '0;

    ecc_scrub_ram #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_flip(wr_flip), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_sec(rd_sec), .rd_ded(rd_ded),
        .sec_count(sec_count), .ded_count(ded_count)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [71:0] mk_flip(input int n);
        logic [71:0] f = '0;
        while ($countones(f) < n)
            f[$urandom_range(71, 0)] = 1'b1;
        return f;
    endfunction

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
        return (c == CMAX) ? c : c + 1'b1;
    endfunction

    // tasks start and end just after a falling edge
    task automatic wr_op(input int a, input logic [63:0] d, input logic [71:0] f);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d; wr_flip = f;
        @(negedge clk);
        wr_en = 1'b0; wr_flip = '0;
        m_data[a] = d; m_flip[a] = f; m_used[a] = 1'b1;
    endtask

    task automatic check_result(input int a, input string tag);
        int n = $countones(m_flip[a]);
        chk({tag, " R2 valid"}, 72'(rd_valid), 72'(1));
        if (n <= 1) chk({tag, " R1 R3 data"}, 72'(rd_data), 72'(m_data[a]));
        chk({tag, " R3 sec flag"}, 72'(rd_sec), 72'(n == 1));
        chk({tag, " R4 R9 ded flag"}, 72'(rd_ded), 72'(n == 2));
        if (n == 1) m_sec = bump(m_sec);
        if (n == 2) m_ded = bump(m_ded);
        chk({tag, " R10 sec_count"}, 72'(sec_count), 72'(m_sec));
        chk({tag, " R11 ded_count"}, 72'(ded_count), 72'(m_ded));
    endtask

    task automatic rd_op(input int a);
        rd_en = 1'b1; rd_addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R2 no result after one edge", 72'(rd_valid), 72'(0));
        @(negedge clk);
        check_result(a, "read");
        if ($countones(m_flip[a]) == 1) m_flip[a] = '0;   // R6 repair expected
        @(negedge clk);
        chk("R5 flags quiet when idle", 72'({rd_sec, rd_ded}), 72'(0));
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 512; i++) begin
            m_used[i] = 1'b0; m_flip[i] = '0; m_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset rd_valid", 72'(rd_valid), 72'(0));
        chk("reset R10 sec_count", 72'(sec_count), 72'(0));
        chk("reset R11 ded_count", 72'(ded_count), 72'(0));

        // R1 clean word
        wr_op(5, 64'hDEAD_BEEF_0123_4567, '0);
        rd_op(5);
        // R3 single flips in parity bit, check bit, first and last data bit; R6 repair
        wr_op(6, 64'hA5A5_5A5A_F00F_0FF0, 72'h1);
        rd_op(6); rd_op(6);
        wr_op(8, 64'h1111_2222_3333_4444, 72'h1 << 71);
        rd_op(8); rd_op(8);
        wr_op(9, 64'h8000_0000_0000_0001, 72'h1 << 1);
        rd_op(9); rd_op(9);
        wr_op(10, 64'hFFFF_FFFF_FFFF_FFFF, 72'h1 << 3);
        rd_op(10); rd_op(10);
        wr_op(11, 64'h0, 72'h1 << 64);
        rd_op(11); rd_op(11);
        // R4 R9 double error persists
        wr_op(7, 64'h0F0F_0F0F_0F0F_0F0F, (72'h1 << 2) | (72'h1 << 40));
        rd_op(7); rd_op(7);

        // R7 user write keeps the port, repair waits
        wr_op(20, 64'hCAFE_0000_0000_0020, 72'h1 << 30);
        rd_en = 1'b1; rd_addr = 20;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b1; wr_addr = 21; wr_data = 64'h21; wr_flip = '0;
        @(negedge clk);
        check_result(20, "R7 first");
        rd_en = 1'b1; rd_addr = 20;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        check_result(20, "R7 busy re-read");
        wr_en = 1'b0;
        m_data[21] = 64'h21; m_flip[21] = '0; m_flip[20] = '0;
        @(negedge clk);
        @(negedge clk);
        rd_op(20);
        rd_op(21);

        // R8 repair discarded by a colliding user write
        wr_op(30, 64'h3030_3030_3030_3030, 72'h1 << 12);
        rd_en = 1'b1; rd_addr = 30;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b1; wr_addr = 31; wr_data = 64'h31; wr_flip = '0;
        @(negedge clk);
        check_result(30, "R8 first");
        wr_addr = 30; wr_data = 64'h7777_6666_5555_4444; wr_flip = 72'h1 << 50;
        @(negedge clk);
        wr_en = 1'b0; wr_flip = '0;
        m_data[31] = 64'h31; m_flip[31] = '0;
        m_data[30] = 64'h7777_6666_5555_4444; m_flip[30] = 72'h1 << 50;
        @(negedge clk);
        @(negedge clk);
        rd_op(30);
        rd_op(30);

        // R11 saturation of the double-error count
        for (int i = 0; i < 16; i++) rd_op(7);
        // R10 saturation of the corrected count
        for (int i = 0; i < 16; i++) begin
            wr_op(40, 64'(i) * 64'h0101_0101_0101_0101, mk_flip(1));
            rd_op(40);
        end

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            int a = 64 + $urandom_range(31, 0);
            if (!m_used[a] || $urandom_range(2, 0) == 0)
                wr_op(a, {$urandom, $urandom}, mk_flip($urandom_range(2, 0)));
            else
                rd_op(a);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule